// File: doc/BRIEF.md
# Inter-Bank Byte Block Copier

This block is a sequencer that copies a run of bytes from one 64K bank of a 24-bit byte-addressed memory to another. Software, or an instruction sequencer around it, gives the source bank, the destination bank, a 16-bit source offset, a 16-bit destination offset, a 16-bit count holding the number of bytes minus one, a step direction and an index-width mode. It then pulses `start_i`. The engine works through a fixed slot of seven clock cycles for each byte. In each slot it issues one read from the source, then one write of that byte to the destination, then waits out the remaining overhead cycles. After each slot it steps both offsets and decrements the count.

Both offsets step up or both step down. Picking the direction lets a caller copy between overlapping regions without damaging bytes that have not been read yet. The move ends when the count passes zero to all ones. A one-cycle `done_o` pulse marks the end. The final offsets and the count stay on the outputs until the next start. In narrow index mode only the low byte of each offset is used, and the high byte is held at zero.

Top module: `bmove_top`

## Requirements
- R1: While `busy_o` is low, `start_i` captures all operands at the clock edge and raises `busy_o` from the next cycle. While `busy_o` is high, `start_i` and all operands are ignored.
- R2: In cycle 0 of each slot the engine issues a read (`mem_req_o`=1, `mem_we_o`=0) at address {source bank, source offset}. In cycle 2 it issues a write (`mem_req_o`=1, `mem_we_o`=1) at {destination bank, destination offset}, carrying the byte returned for that read. `mem_req_o` is low in the other five cycles.
- R3: Each byte takes exactly 7 cycles, so `busy_o` stays high for 7*(count+1) cycles.
- R4: After each byte, both offsets step by +1 when `dir_down_i`=0 and by -1 when `dir_down_i`=1, wrapping modulo 2^16.
- R5: The count decrements by one after each byte. The move ends after the byte in which the count was 0, leaving the count at 16'hFFFF. A start count of 0 moves exactly one byte.
- R6: `done_o` is high for exactly one cycle, the first cycle after the final slot, and `busy_o` is low in that cycle.
- R7: When `narrow_idx_i`=1 at start, both offsets load with their high byte forced to zero. The low bytes step with wrap modulo 256, so each address is {bank, 8'h00, low byte}.
- R8: An overlapping copy arrives intact when the move ascends for a destination below the source and descends for a destination above it.
- R9: After the move, the offsets, the count and the idle outputs hold their values until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a move (taken only while idle) |
| dir_down_i | input | 1 | 0: offsets ascend, 1: offsets descend |
| narrow_idx_i | input | 1 | 1: 8-bit offsets, high bytes zero |
| src_bank_i | input | 8 | Source bank |
| dst_bank_i | input | 8 | Destination bank |
| src_off_i | input | 16 | Source offset start value |
| dst_off_i | input | 16 | Destination offset start value |
| count_i | input | 16 | Bytes to move minus one |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 write, 0 read |
| mem_addr_o | output | 24 | Byte address {bank, offset} |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid in the cycle after the read request |
| src_off_o | output | 16 | Current source offset |
| dst_off_o | output | 16 | Current destination offset |
| count_o | output | 16 | Current count |
| busy_o | output | 1 | Move in progress |
| done_o | output | 1 | One-cycle end-of-move pulse |

## Verification
The assertions assume a memory that returns read data exactly one cycle after the read request and never stalls. The bench's memory model is a registered read of that latency. The assertions also assume that a move is started with a direction suited to any overlap. The directed scenarios pick ascending moves for destinations below the source and descending moves for destinations above it. Operands that change during a move are assumed to be ignored. The bench deliberately presents a second start with different operands mid-move to confirm this.

// File: rtl/bmove_pkg.sv
package bmove_pkg;
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } move_dir_e;

  // Number of offset registers stepped in lock-step (source, destination).
  localparam int NUM_PTR = 2;
  localparam int PTR_SRC = 0;
  localparam int PTR_DST = 1;
endpackage

// File: rtl/bmove_rst_sync.sv
module bmove_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync_o = sync_q[1];
endmodule

// File: rtl/bmove_slot_ctl.sv
module bmove_slot_ctl #(
  parameter int SLOT_CYC = 7,
  parameter int RD_SLOT  = 0,
  parameter int WR_SLOT  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic last_i,
  output logic load_o,
  output logic rd_o,
  output logic wr_o,
  output logic cap_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  localparam int PH_W = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(SLOT_CYC - 1);
  localparam logic [PH_W-1:0] RD_PH   = PH_W'(RD_SLOT);
  localparam logic [PH_W-1:0] CAP_PH  = PH_W'(RD_SLOT + 1);
  localparam logic [PH_W-1:0] WR_PH   = PH_W'(WR_SLOT);

  logic            busy_q, busy_d;
  logic            done_q, done_d;
  logic [PH_W-1:0] phase_q, phase_d;
  logic            phase_en;

  always_comb begin
    load_o   = start_i & ~busy_q;
    step_o   = busy_q & (phase_q == LAST_PH);
    rd_o     = busy_q & (phase_q == RD_PH);
    wr_o     = busy_q & (phase_q == WR_PH);
    cap_o    = busy_q & (phase_q == CAP_PH);
    done_d   = step_o & last_i;
    busy_d   = busy_q;
    phase_d  = phase_q;
    phase_en = load_o | busy_q;
    if (load_o) begin
      busy_d  = 1'b1;
      phase_d = '0;
    end else if (step_o) begin
      phase_d = '0;
      if (last_i) busy_d = 1'b0;
    end else if (busy_q) begin
      phase_d = phase_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      phase_q <= '0;
    end else begin
      done_q <= done_d;
      busy_q <= busy_d;
      if (phase_en) phase_q <= phase_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;

  p_slot_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !step_o) |=> (phase_q == $past(phase_q) + 1'b1));
  p_slot_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o && !last_i) |=> (busy_q && phase_q == '0));
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);
  p_start_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_q) |=> (busy_q && phase_q == '0));
endmodule

// File: rtl/bmove_offset_reg.sv
module bmove_offset_reg #(
  parameter int W  = 16,
  parameter int NW = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         load_narrow_i,
  input  logic         step_i,
  input  bmove_pkg::move_dir_e dir_i,
  input  logic         narrow_i,
  output logic [W-1:0] val_o
);
  import bmove_pkg::*;

  logic [W-1:0]  val_q, val_d;
  logic          val_en;
  logic [NW-1:0] lo_nxt;
  logic [W-1:0]  full_nxt;

  always_comb begin
    lo_nxt   = (dir_i == DIR_DOWN) ? (val_q[NW-1:0] - NW'(1)) : (val_q[NW-1:0] + NW'(1));
    full_nxt = (dir_i == DIR_DOWN) ? (val_q - W'(1)) : (val_q + W'(1));
    val_en   = load_i | step_i;
    val_d    = val_q;
    if (load_i) begin
      val_d = load_narrow_i ? {{(W-NW){1'b0}}, load_val_i[NW-1:0]} : load_val_i;
    end else if (step_i) begin
      val_d = narrow_i ? {{(W-NW){1'b0}}, lo_nxt} : full_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      val_q <= '0;
    else if (val_en) val_q <= val_d;
  end

  assign val_o = val_q;

  p_step_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && !narrow_i && dir_i == DIR_UP) |=> (val_q == $past(val_q) + W'(1)));
  p_step_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && !narrow_i && dir_i == DIR_DOWN) |=> (val_q == $past(val_q) - W'(1)));
  p_hi_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    narrow_i |-> (val_q[W-1:NW] == '0));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !step_i) |=> $stable(val_q));
endmodule

// File: rtl/bmove_counter.sv
module bmove_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         step_i,
  output logic [W-1:0] val_o,
  output logic         last_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load_i | step_i;
    cnt_d  = load_i ? load_val_i : (cnt_q - W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign val_o  = cnt_q;
  assign last_o = (cnt_q == '0);

  p_count_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i) |=> (cnt_q == $past(cnt_q) - W'(1)));
  p_count_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && cnt_q == '0) |=> (cnt_q == '1));
endmodule

// File: rtl/bmove_top.sv
module bmove_top #(
  parameter int BANK_W   = 8,
  parameter int OFF_W    = 16,
  parameter int CNT_W    = 16,
  parameter int DATA_W   = 8,
  parameter int NARROW_W = 8,
  parameter int SLOT_CYC = 7,
  parameter int RD_SLOT  = 0,
  parameter int WR_SLOT  = 2,
  localparam int ADDR_W  = BANK_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              dir_down_i,
  input  logic              narrow_idx_i,
  input  logic [BANK_W-1:0] src_bank_i,
  input  logic [BANK_W-1:0] dst_bank_i,
  input  logic [OFF_W-1:0]  src_off_i,
  input  logic [OFF_W-1:0]  dst_off_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [OFF_W-1:0]  src_off_o,
  output logic [OFF_W-1:0]  dst_off_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              busy_o,
  output logic              done_o
);
  import bmove_pkg::*;

  logic rst_n_s;
  logic load, rd, wr, cap, step, last;

  logic [BANK_W-1:0] src_bank_q, dst_bank_q;
  logic              narrow_q;
  move_dir_e         dir_q, dir_d;
  logic [DATA_W-1:0] data_q;

  logic [OFF_W-1:0] ptr_init [NUM_PTR];
  logic [OFF_W-1:0] ptr_val  [NUM_PTR];

  bmove_rst_sync u_rst (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_n_sync_o (rst_n_s)
  );

  bmove_slot_ctl #(
    .SLOT_CYC (SLOT_CYC),
    .RD_SLOT  (RD_SLOT),
    .WR_SLOT  (WR_SLOT)
  ) u_ctl (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .start_i (start_i),
    .last_i  (last),
    .load_o  (load),
    .rd_o    (rd),
    .wr_o    (wr),
    .cap_o   (cap),
    .step_o  (step),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  bmove_counter #(.W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .load_i     (load),
    .load_val_i (count_i),
    .step_i     (step),
    .val_o      (count_o),
    .last_o     (last)
  );

  assign ptr_init[PTR_SRC] = src_off_i;
  assign ptr_init[PTR_DST] = dst_off_i;

  for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
    bmove_offset_reg #(.W(OFF_W), .NW(NARROW_W)) u_off (
      .clk           (clk),
      .rst_n         (rst_n_s),
      .load_i        (load),
      .load_val_i    (ptr_init[g]),
      .load_narrow_i (narrow_idx_i),
      .step_i        (step),
      .dir_i         (dir_q),
      .narrow_i      (narrow_q),
      .val_o         (ptr_val[g])
    );
  end

  assign dir_d = dir_down_i ? DIR_DOWN : DIR_UP;

  // Operand context, captured once per move
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      src_bank_q <= '0;
      dst_bank_q <= '0;
      narrow_q   <= 1'b0;
      dir_q      <= DIR_UP;
    end else if (load) begin
      src_bank_q <= src_bank_i;
      dst_bank_q <= dst_bank_i;
      narrow_q   <= narrow_idx_i;
      dir_q      <= dir_d;
    end
  end

  // Byte holding register, loaded the cycle read data returns
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)  data_q <= '0;
    else if (cap)  data_q <= mem_rdata_i;
  end

  always_comb begin
    mem_req_o   = rd | wr;
    mem_we_o    = wr;
    mem_addr_o  = wr ? {dst_bank_q, ptr_val[PTR_DST]} : {src_bank_q, ptr_val[PTR_SRC]};
    mem_wdata_o = data_q;
  end

  assign src_off_o = ptr_val[PTR_SRC];
  assign dst_off_o = ptr_val[PTR_DST];

  p_req_in_move_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    mem_req_o |-> busy_o);
  p_write_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mem_req_o && !mem_we_o) |=> !mem_req_o);
  p_ctx_hold_r1: assert property (@(posedge clk) disable iff (!rst_n_s)
    (busy_o && start_i) |=> ($stable(src_bank_q) && $stable(dst_bank_q) && $stable(dir_q)));
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!busy_o && !start_i) |=> ($stable(count_o) && !mem_req_o));
endmodule

// File: tb/tb_bmove_top.sv
module tb_bmove_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, dir_down_i = 1'b0, narrow_idx_i = 1'b0;
  logic [7:0]  src_bank_i = '0, dst_bank_i = '0;
  logic [15:0] src_off_i = '0, dst_off_i = '0, count_i = '0;
  logic        mem_req_o, mem_we_o, busy_o, done_o;
  logic [23:0] mem_addr_o;
  logic [7:0]  mem_wdata_o;
  logic [7:0]  mem_rdata_i = '0;
  logic [15:0] src_off_o, dst_off_o, count_o;

  int checks = 0, bad = 0, cyc = 0;
  localparam int WDOG = 150000;

  always #2 clk = ~clk;  // 250 MHz

  bmove_top dut (.*);

  // Memory model: read data returned one cycle after the request
  logic [7:0] mem_q [logic [23:0]];
  function automatic logic [7:0] peek(input logic [23:0] a);
    if (mem_q.exists(a)) return mem_q[a];
    return a[7:0] ^ (a[15:8] * 8'd3) ^ (a[23:16] * 8'd7) ^ 8'h5A;
  endfunction
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req_o && !mem_we_o) mem_rdata_i <= peek(mem_addr_o);
    if (mem_req_o && mem_we_o)  mem_q[mem_addr_o] = mem_wdata_o;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] off_at(input logic [15:0] b, input int k, input bit down, input bit nar);
    logic [7:0] lo;
    if (nar) begin
      lo = down ? (b[7:0] - 8'(k)) : (b[7:0] + 8'(k));
      return {8'h00, lo};
    end
    return down ? (b - 16'(k)) : (b + 16'(k));
  endfunction

  // One move; poke=1 presents a conflicting start mid-move (R1)
  task automatic run_move(input string name, input logic [7:0] sb, input logic [7:0] db,
                          input logic [15:0] x, input logic [15:0] y, input logic [15:0] c,
                          input bit down, input bit nar, input bit poke);
    int n = int'(c) + 1;
    logic [7:0] orig [0:63];
    int k = 0, perr = 0;
    for (int i = 0; i < n; i++) orig[i] = peek({sb, off_at(x, i, down, nar)});
    @(negedge clk);
    start_i = 1'b1; dir_down_i = down; narrow_idx_i = nar;
    src_bank_i = sb; dst_bank_i = db; src_off_i = x; dst_off_i = y; count_i = c;
    @(negedge clk);
    start_i = 1'b0;
    src_bank_i = 8'hEE; dst_bank_i = 8'hDD; src_off_i = 16'h1357; dst_off_i = 16'h2468; count_i = 16'h0009;
    while (busy_o && cyc < WDOG) begin
      int ph = k % 7, sl = k / 7;
      if (ph == 0) begin
        if (!(mem_req_o && !mem_we_o && mem_addr_o == {sb, off_at(x, sl, down, nar)})) perr++;
      end else if (ph == 2) begin
        if (!(mem_req_o && mem_we_o && mem_addr_o == {db, off_at(y, sl, down, nar)} &&
              mem_wdata_o == orig[sl])) perr++;
      end else if (mem_req_o) perr++;
      start_i = poke && (k == 9);
      dir_down_i = ~down;
      k++;
      @(negedge clk);
    end
    start_i = 1'b0;
    chk(perr == 0, {name, " R2 access pattern errors"}, perr, 0);
    chk(k == 7 * n, {name, " R3 busy cycles"}, k, 7 * n);
    chk(done_o && !busy_o, {name, " R6 done after last slot"}, {busy_o, done_o}, 2'b01);
    chk(src_off_o == off_at(x, n, down, nar), {name, " R4 final source offset"}, src_off_o, off_at(x, n, down, nar));
    chk(dst_off_o == off_at(y, n, down, nar), {name, " R4 final destination offset"}, dst_off_o, off_at(y, n, down, nar));
    chk(count_o == 16'hFFFF, {name, " R5 final count"}, count_o, 16'hFFFF);
    perr = 0;
    for (int i = 0; i < n; i++) if (peek({db, off_at(y, i, down, nar)}) != orig[i]) perr++;
    chk(perr == 0, {name, " R8 destination bytes wrong"}, perr, 0);
    @(negedge clk);
    chk(!done_o, {name, " R6 done one cycle only"}, done_o, 0);
  endtask

  task automatic t_reset;
    chk(!busy_o && !done_o && !mem_req_o, "reset R1 idle", {busy_o, done_o, mem_req_o}, 0);
    chk(count_o == 0 && src_off_o == 0 && dst_off_o == 0, "reset R9 outputs zero", count_o, 0);
  endtask

  task automatic t_hold;
    logic [15:0] xs = src_off_o, ys = dst_off_o, cs = count_o;
    repeat (6) @(negedge clk);
    chk(xs == src_off_o && ys == dst_off_o && cs == count_o && !busy_o && !mem_req_o,
        "hold R9 values after move", {src_off_o, dst_off_o}, {xs, ys});
  endtask

  task automatic t_narrow;
    run_move("narrow R7", 8'h05, 8'h06, 16'h12FE, 16'h34FF, 16'h0002, 1'b0, 1'b1, 1'b0);
    chk(src_off_o == 16'h0001 && dst_off_o == 16'h0002, "narrow R7 wrap in low byte",
        {src_off_o, dst_off_o}, 32'h0001_0002);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    run_move("ascend", 8'h01, 8'h02, 16'h0100, 16'h0400, 16'h0004, 1'b0, 1'b0, 1'b0);
    t_hold();
    run_move("descend", 8'h03, 8'h04, 16'h0210, 16'h0090, 16'h0003, 1'b1, 1'b0, 1'b0);
    run_move("single R5", 8'h07, 8'h08, 16'h0555, 16'h0666, 16'h0000, 1'b0, 1'b0, 1'b0);
    run_move("wrap R4", 8'h09, 8'h0A, 16'hFFFE, 16'hFFFF, 16'h0002, 1'b0, 1'b0, 1'b0);
    run_move("overlap up R8", 8'h0B, 8'h0B, 16'h0100, 16'h00FE, 16'h0007, 1'b0, 1'b0, 1'b0);
    run_move("overlap down R8", 8'h0C, 8'h0C, 16'h0207, 16'h020A, 16'h0007, 1'b1, 1'b0, 1'b0);
    t_narrow();
    run_move("restart ignored R1", 8'h0D, 8'h0E, 16'h0030, 16'h0040, 16'h0003, 1'b0, 1'b0, 1'b1);
    t_hold();
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    wait (cyc >= WDOG);
    bad++;
    checks++;
    $display("FAIL watchdog expired act=%0d exp<%0d", cyc, WDOG);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule